// File: doc/BRIEF.md
# Virtual-Lane Switch Allocation Table

This block is the central connection manager of a five-port mesh router whose four neighbour-facing ports are each split into several virtual lanes, while the port toward the attached core carries a single lane. Every input lane that holds the first flit of a packet raises a request. A rotating arbiter picks one requester at a time. The arbiter reads the destination coordinates from that lane's header and applies dimension-ordered routing, which resolves X before Y. If the chosen output port still has an idle lane, the block records the connection.

The connection store is deliberately redundant. A forward entry per input lane names the output lane it drives. A backward entry per output lane names the input lane that feeds it. A per-output-lane idle flag marks which output lanes are free. The crossbar and the link schedulers read these vectors directly as their select lines. When the flit counter of an output lane sees a packet's last flit, it sends a one-cycle release pulse, and that pulse tears the connection down. Each routing decision takes a fixed, parameterised number of cycles. A header whose target port is fully occupied gets no grant, and it competes again in later rounds.

Top module: `vc_switch_alloc`

## Requirements
- R1: Lane identifiers are port index times LANES plus lane index. The port indices are East 0, West 1, North 2, South 3 and Local 4. The Local port has a single lane with identifier 4*LANES, so N = 4*LANES+1 identifiers exist. Lane i of a port-wide vector sits at bit i. A table entry for identifier i sits at bits [i*IDW +: IDW], where IDW = $clog2(N).
- R2: After reset, every bit of `free_o` is 1 and `conn_o`, `grant_o`, `in_tab_o` and `out_tab_o` are all zero.
- R3: The header carries the destination X in its upper FLIT_W/2 bits and Y in its lower FLIT_W/2 bits, and `here_i` packs this router's own coordinates the same way. Coordinates are compared unsigned. A larger destination X routes to East and a smaller one to West. When X matches, a larger Y routes to North and a smaller one to South. When both match, the packet goes to Local.
- R4: The lowest-numbered free lane of the target port is assigned.
- R5: A successful allocation does four things: it sets `in_tab` of the input lane to the output lane, sets `out_tab` of the output lane to the input lane, clears that output lane's `free` bit and sets the input lane's `conn` bit. In the same cycle, `grant_o` pulses high for one cycle at the input lane's bit only.
- R6: A request sampled at a clock edge while the block is idle produces its grant and table update exactly ROUTE_CYC edges later (ROUTE_CYC is at least 6, 6 by default). Two grants never occur in consecutive cycles.
- R7: The arbiter starts its search at the lane after the one served last, wrapping around, so a lower-numbered requester does not win over the lane that follows the last winner. After reset, the search starts at lane 0.
- R8: If the target port has no free lane, no grant is given and the table is unchanged. The request keeps competing, and once a lane of that port is released the header is granted.
- R9: A release pulse on a busy output lane sets its `free` bit on the next edge and clears its `out_tab` entry, plus the `in_tab` entry and `conn` bit of its input lane. A release on an output lane that is already free changes nothing.
- R10: A request from an input lane whose `conn` bit is set is ignored. No grant is given and its table entries stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N | Per input lane: header flit waiting for routing |
| hdr_i | input | N*FLIT_W | Per input lane: header flit holding the destination X and Y |
| here_i | input | FLIT_W | This router's X (upper half) and Y (lower half) |
| rel_i | input | N | Per output lane: one-cycle release pulse at packet end |
| grant_o | output | N | One-cycle pulse at the input lane just connected |
| conn_o | output | N | Per input lane: connection held |
| in_tab_o | output | N*IDW | Per input lane: output lane driven |
| out_tab_o | output | N*IDW | Per output lane: input lane feeding it |
| free_o | output | N | Per output lane: 1 when idle |

## Verification
Single headers are aimed at each of the five directions, including one with both an X and a Y offset. These show that X is resolved before Y and that the identifier arithmetic lands on the right lane. Two headers for the same neighbour port tell lowest-lane assignment apart from any other choice. A third header for that port, and a second header for the single-lane core port, show that a header blocks and then resumes after a release. Simultaneous requests placed on both sides of the last winner show that priority rotates rather than staying fixed. Requests held high by lanes that are already connected, and releases aimed at idle lanes, check that neither disturbs the table.

// File: rtl/vcsw_pkg.sv
package vcsw_pkg;
   localparam int unsigned MESH_PORTS = 4;
   localparam int unsigned ALL_PORTS  = 5;

   typedef enum logic [2:0] {
      PT_EAST  = 3'd0,
      PT_WEST  = 3'd1,
      PT_NORTH = 3'd2,
      PT_SOUTH = 3'd3,
      PT_LOCAL = 3'd4
   } port_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_ROUTE = 2'd2
   } fsm_e;
endpackage

// File: rtl/vcsw_rr_arb.sv
module vcsw_rr_arb #(
   parameter int unsigned N   = 9,
   parameter int unsigned IDW = 4
) (
   input  logic [N-1:0]   req_i,
   input  logic [IDW-1:0] last_i,
   output logic           hit_o,
   output logic [IDW-1:0] win_o
);
   generate
      if (N == 1) begin : g_single
         assign hit_o = req_i[0];
         assign win_o = '0;
      end else begin : g_rotate
         always_comb begin
            int idx;
            hit_o = 1'b0;
            win_o = '0;
            for (int k = 1; k <= int'(N); k++) begin
               idx = (int'(last_i) + k) % int'(N);
               if (!hit_o && req_i[idx]) begin
                  hit_o = 1'b1;
                  win_o = IDW'(idx);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vcsw_xy_route.sv
module vcsw_xy_route
   import vcsw_pkg::*;
#(
   parameter int unsigned FLIT_W = 8
) (
   input  logic [FLIT_W-1:0] dest_i,
   input  logic [FLIT_W-1:0] here_i,
   output port_e             port_o
);
   localparam int unsigned HALF = FLIT_W / 2;

   logic [HALF-1:0] dx, dy, hx, hy;
   assign dx = dest_i[FLIT_W-1:HALF];
   assign dy = dest_i[HALF-1:0];
   assign hx = here_i[FLIT_W-1:HALF];
   assign hy = here_i[HALF-1:0];

   always_comb begin
      if (dx > hx)      port_o = PT_EAST;
      else if (dx < hx) port_o = PT_WEST;
      else if (dy > hy) port_o = PT_NORTH;
      else if (dy < hy) port_o = PT_SOUTH;
      else              port_o = PT_LOCAL;
   end
endmodule

// File: rtl/vcsw_lane_pick.sv
module vcsw_lane_pick
   import vcsw_pkg::*;
#(
   parameter int unsigned LANES = 2,
   parameter int unsigned N     = 9,
   parameter int unsigned IDW   = 4
) (
   input  logic [N-1:0]   free_i,
   input  port_e          port_i,
   output logic           found_o,
   output logic [IDW-1:0] lane_o
);
   always_comb begin
      int base;
      int cand;
      found_o = 1'b0;
      lane_o  = '0;
      base    = int'(port_i) * int'(LANES);
      for (int l = 0; l < int'(LANES); l++) begin
         cand = base + l;
         if (!found_o && (port_i != PT_LOCAL || l == 0) && cand < int'(N)) begin
            if (free_i[cand]) begin
               found_o = 1'b1;
               lane_o  = IDW'(cand);
            end
         end
      end
   end
endmodule

// File: rtl/vcsw_table.sv
module vcsw_table #(
   parameter int unsigned N   = 9,
   parameter int unsigned IDW = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_en_i,
   input  logic [IDW-1:0]          alloc_in_i,
   input  logic [IDW-1:0]          alloc_out_i,
   input  logic [N-1:0]            rel_i,
   output logic [N-1:0][IDW-1:0]   in_tab_o,
   output logic [N-1:0][IDW-1:0]   out_tab_o,
   output logic [N-1:0]            conn_o,
   output logic [N-1:0]            free_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_tab_o  <= '0;
         out_tab_o <= '0;
         conn_o    <= '0;
         free_o    <= '1;
      end else begin
         for (int r = 0; r < int'(N); r++) begin
            if (rel_i[r] && !free_o[r]) begin
               free_o[r]                <= 1'b1;
               out_tab_o[r]             <= '0;
               conn_o[out_tab_o[r]]     <= 1'b0;
               in_tab_o[out_tab_o[r]]   <= '0;
            end
         end
         if (alloc_en_i) begin
            free_o[alloc_out_i]    <= 1'b0;
            out_tab_o[alloc_out_i] <= alloc_in_i;
            in_tab_o[alloc_in_i]   <= alloc_out_i;
            conn_o[alloc_in_i]     <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/vc_switch_alloc.sv
module vc_switch_alloc
   import vcsw_pkg::*;
#(
   parameter int unsigned LANES     = 2,
   parameter int unsigned FLIT_W    = 8,
   parameter int unsigned ROUTE_CYC = 6,
   localparam int unsigned N        = MESH_PORTS * LANES + 1,
   localparam int unsigned IDW      = $clog2(N)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        req_i,
   input  logic [N*FLIT_W-1:0] hdr_i,
   input  logic [FLIT_W-1:0]   here_i,
   input  logic [N-1:0]        rel_i,
   output logic [N-1:0]        grant_o,
   output logic [N-1:0]        conn_o,
   output logic [N*IDW-1:0]    in_tab_o,
   output logic [N*IDW-1:0]    out_tab_o,
   output logic [N-1:0]        free_o
);
   localparam int unsigned CW = $clog2(ROUTE_CYC + 1);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (FLIT_W < 2 || (FLIT_W % 2) != 0) begin : g_bad_flit
      $error("FLIT_W must be even and at least 2");
   end
   if (ROUTE_CYC < 6) begin : g_bad_lat
      $error("ROUTE_CYC must be at least 6");
   end

   logic [N-1:0][FLIT_W-1:0] hdr_v;
   logic [N-1:0][IDW-1:0]    in_tab_v, out_tab_v;
   assign hdr_v     = hdr_i;
   assign in_tab_o  = in_tab_v;
   assign out_tab_o = out_tab_v;

   fsm_e           state_q;
   logic [CW-1:0]  cnt_q;
   logic [IDW-1:0] win_q, last_q;
   logic [N-1:0]   grant_q;

   logic           arb_hit;
   logic [IDW-1:0] arb_win;
   logic [N-1:0]   eligible;
   port_e          tgt_port;
   logic           lane_found;
   logic [IDW-1:0] lane_id;
   logic           alloc_en;

   assign eligible = req_i & ~conn_o;
   assign grant_o  = grant_q;

   vcsw_rr_arb #(.N(N), .IDW(IDW)) u_arb (
      .req_i  (eligible),
      .last_i (last_q),
      .hit_o  (arb_hit),
      .win_o  (arb_win)
   );

   vcsw_xy_route #(.FLIT_W(FLIT_W)) u_route (
      .dest_i (hdr_v[win_q]),
      .here_i (here_i),
      .port_o (tgt_port)
   );

   vcsw_lane_pick #(.LANES(LANES), .N(N), .IDW(IDW)) u_pick (
      .free_i  (free_o),
      .port_i  (tgt_port),
      .found_o (lane_found),
      .lane_o  (lane_id)
   );

   assign alloc_en = (state_q == ST_ROUTE) && req_i[win_q] && lane_found;

   vcsw_table #(.N(N), .IDW(IDW)) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_en_i  (alloc_en),
      .alloc_in_i  (win_q),
      .alloc_out_i (lane_id),
      .rel_i       (rel_i),
      .in_tab_o    (in_tab_v),
      .out_tab_o   (out_tab_v),
      .conn_o      (conn_o),
      .free_o      (free_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         win_q   <= '0;
         last_q  <= IDW'(N - 1);
         grant_q <= '0;
      end else begin
         grant_q <= '0;
         case (state_q)
            ST_IDLE: begin
               if (arb_hit) begin
                  win_q   <= arb_win;
                  cnt_q   <= CW'(1);
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (cnt_q == CW'(ROUTE_CYC - 1)) state_q <= ST_ROUTE;
               else                             cnt_q   <= cnt_q + CW'(1);
            end
            ST_ROUTE: begin
               state_q <= ST_IDLE;
               last_q  <= win_q;
               if (alloc_en) grant_q[win_q] <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vc_switch_alloc_chk.sv
module vc_switch_alloc_chk #(
   parameter int unsigned LANES     = 2,
   parameter int unsigned FLIT_W    = 8,
   parameter int unsigned ROUTE_CYC = 6,
   localparam int unsigned N        = 4 * LANES + 1,
   localparam int unsigned IDW      = $clog2(N)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N-1:0]        req_i,
   input logic [N*FLIT_W-1:0] hdr_i,
   input logic [FLIT_W-1:0]   here_i,
   input logic [N-1:0]        rel_i,
   input logic [N-1:0]        grant_o,
   input logic [N-1:0]        conn_o,
   input logic [N*IDW-1:0]    in_tab_o,
   input logic [N*IDW-1:0]    out_tab_o,
   input logic [N-1:0]        free_o
);
   logic [N-1:0][IDW-1:0] in_v, out_v;
   assign in_v  = in_tab_o;
   assign out_v = out_tab_o;

   a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   a_r6_grant_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |=> (grant_o == '0));

   for (genvar i = 0; i < int'(N); i++) begin : g_lane
      a_r5_grant_connects: assert property (@(posedge clk) disable iff (!rst_n)
         grant_o[i] |-> conn_o[i]);

      a_r10_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
         grant_o[i] |-> !$past(conn_o[i]));

      a_r9_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
         (rel_i[i] && !free_o[i]) |=> free_o[i]);

      a_r1_table_consistent: assert property (@(posedge clk) disable iff (!rst_n)
         !free_o[i] |-> (conn_o[out_v[i]] && in_v[out_v[i]] == IDW'(i)));
   end
endmodule

bind vc_switch_alloc vc_switch_alloc_chk #(
   .LANES(LANES), .FLIT_W(FLIT_W), .ROUTE_CYC(ROUTE_CYC)
) u_chk (.*);

// File: tb/vc_switch_alloc_bench.sv
module vc_switch_alloc_bench;
   localparam int LANES = 2;
   localparam int FLIT_W = 8;
   localparam int ROUTE_CYC = 6;
   localparam int N = 4 * LANES + 1;
   localparam int IDW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]        req = '0;
   logic [N*FLIT_W-1:0] hdr = '0;
   logic [FLIT_W-1:0]   here = 8'h22;
   logic [N-1:0]        rel = '0;
   logic [N-1:0]        grant_o, conn_o, free_o;
   logic [N*IDW-1:0]    in_tab_o, out_tab_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   vc_switch_alloc #(.LANES(LANES), .FLIT_W(FLIT_W), .ROUTE_CYC(ROUTE_CYC)) u_vc_switch_alloc (
      .clk(clk), .rst_n(rst_n), .req_i(req), .hdr_i(hdr), .here_i(here), .rel_i(rel),
      .grant_o(grant_o), .conn_o(conn_o), .in_tab_o(in_tab_o), .out_tab_o(out_tab_o),
      .free_o(free_o)
   );

   // vector: {lane, dest X, dest Y, expected output lane}, here = (2,2)
   localparam logic [15:0] VEC [6] = '{
      {4'd0, 4'd3, 4'd2, 4'd0},   // East
      {4'd2, 4'd0, 4'd5, 4'd2},   // West
      {4'd4, 4'd2, 4'd7, 4'd4},   // North
      {4'd6, 4'd2, 4'd0, 4'd6},   // South
      {4'd8, 4'd2, 4'd2, 4'd8},   // Local
      {4'd1, 4'd5, 4'd0, 4'd0}    // X first, then Y
   };

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int in_of(input int l);
      return int'(in_tab_o[l*IDW +: IDW]);
   endfunction

   function automatic int out_of(input int l);
      return int'(out_tab_o[l*IDW +: IDW]);
   endfunction

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = '0; rel = '0; hdr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_req(input int lane, input logic [3:0] dx, input logic [3:0] dy);
      hdr[lane*FLIT_W +: FLIT_W] = {dx, dy};
      req[lane] = 1'b1;
   endtask

   task automatic wait_grant(input int lane, input int limit, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!grant_o[lane] && n < limit);
      if (!grant_o[lane]) n = -1;
   endtask

   task automatic pulse_rel(input int o);
      rel[o] = 1'b1;
      @(negedge clk);
      rel[o] = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int n;
      do_reset();
      // R2 reset state
      check("R2 free", int'(free_o), (1 << N) - 1);
      check("R2 conn", int'(conn_o), 0);
      check("R2 grant", int'(grant_o), 0);
      check("R2 in_tab", int'(in_tab_o != '0), 0);

      // vector walk: R1 R3 R5 R6 R9
      for (int v = 0; v < 6; v++) begin
         int lane, exp;
         lane = int'(VEC[v][15:12]);
         exp  = int'(VEC[v][3:0]);
         set_req(lane, VEC[v][11:8], VEC[v][7:4]);
         wait_grant(lane, 40, n);
         req[lane] = 1'b0;
         check("R6 latency", n, ROUTE_CYC + 1);
         check("R5 grant onehot", int'(grant_o), 1 << lane);
         check("R3 in_tab", in_of(lane), exp);
         check("R1 out_tab", out_of(exp), lane);
         check("R5 free cleared", int'(free_o[exp]), 0);
         check("R5 conn set", int'(conn_o[lane]), 1);
         @(negedge clk);
         check("R5 grant single cycle", int'(grant_o), 0);
         pulse_rel(exp);
         check("R9 free set", int'(free_o[exp]), 1);
         check("R9 conn cleared", int'(conn_o[lane]), 0);
         check("R9 in_tab cleared", in_of(lane), 0);
      end

      // R4 lowest free lane, R8 blocking, R10 connected request ignored
      do_reset();
      set_req(0, 4'd3, 4'd2);
      wait_grant(0, 40, n);
      check("R4 first east lane", in_of(0), 0);
      set_req(2, 4'd7, 4'd1);
      wait_grant(2, 40, n);
      check("R4 second east lane", in_of(2), 1);
      set_req(4, 4'd9, 4'd9);
      wait_grant(4, 30, n);
      check("R8 blocked no grant", n, -1);
      check("R10 connected lane not regranted", int'(grant_o[0]), 0);
      check("R10 table kept", in_of(0), 0);
      check("R8 east lanes busy", int'(free_o[1:0]), 0);
      req[0] = 1'b0; req[2] = 1'b0;
      pulse_rel(0);
      wait_grant(4, 30, n);
      req[4] = 1'b0;
      check("R8 granted after release", int'(n > 0), 1);
      check("R8 reuse lane", in_of(4), 0);

      // single local lane, R9 release of a free lane
      do_reset();
      set_req(0, 4'd2, 4'd2);
      set_req(1, 4'd2, 4'd2);
      wait_grant(0, 40, n);
      req[0] = 1'b0;
      check("R1 local id", in_of(0), 4 * LANES);
      wait_grant(1, 25, n);
      check("R8 local blocked", n, -1);
      pulse_rel(3);
      check("R9 free lane release ignored", int'(free_o), ((1 << N) - 1) & ~(1 << (4 * LANES)));
      check("R9 connection kept", out_of(4 * LANES), 0);
      pulse_rel(4 * LANES);
      wait_grant(1, 30, n);
      req[1] = 1'b0;
      check("R8 local after release", out_of(4 * LANES), 1);

      // R7 round robin
      do_reset();
      set_req(1, 4'd2, 4'd7);
      set_req(5, 4'd2, 4'd0);
      wait_grant(1, 40, n);
      req[1] = 1'b0;
      check("R7 lowest after reset", int'(grant_o), 1 << 1);
      wait_grant(5, 40, n);
      req[5] = 1'b0;
      check("R7 second requester", int'(grant_o), 1 << 5);
      set_req(2, 4'd6, 4'd2);
      set_req(7, 4'd0, 4'd2);
      wait_grant(7, 40, n);
      req[7] = 1'b0;
      check("R7 rotate past last winner", int'(grant_o), 1 << 7);
      check("R7 lane 2 waits", int'(conn_o[2]), 0);
      wait_grant(2, 40, n);
      req[2] = 1'b0;
      check("R7 lane 2 next", in_of(2), 0);

      done = 1;
      finish_run();
   end
endmodule